// File: doc/BRIEF.md
# LED Driver Fault and Shutdown Monitor

This block watches the protection conditions of a multi-channel constant-current LED driver and decides when every output has to be forced off. A watchdog checks that an external scan-trigger signal keeps toggling. If the signal goes quiet for longer than a programmed number of clock cycles, the channels are switched off. This guards the LEDs when the display scan has stalled. A thermal-shutdown event also switches the channels off, but only while its enable pin is high. An active-low blank input turns the outputs off directly, without counting as a fault.

Two active-low flags report faults in open-drain style, each as a data bit plus an output enable. The shutdown flag covers watchdog and thermal shutdowns. The disconnection flag covers open-LED reports from any channel and can be forced by an active-low test input. The scan-trigger, the thermal event and the thermal enable each pass through a two-flop synchronizer before use.

A small state machine holds the shutdown reason. It has three states:
- `ST_RUN`: normal operation.
- `ST_WDT_TRIP`: shut down by the watchdog.
- `ST_HOT_TRIP`: shut down by a thermal event.

Its transitions are:
- RUN→HOT_TRIP on an enabled thermal event.
- RUN→WDT_TRIP on a watchdog expiry.
- WDT_TRIP→HOT_TRIP on an enabled thermal event, because thermal has priority.
- WDT_TRIP→RUN when scan activity resumes.
- HOT_TRIP→RUN when the thermal event clears and the watchdog is not expired.
- HOT_TRIP→WDT_TRIP when the thermal event clears while the watchdog is still expired.

Top module: `led_fault_monitor`

## Requirements
- R1: After reset, with `blank_n` high, every bit of `ch_enable` is 1, both flags are released (`*_oe`=0, `*_d`=1) and the state is `ST_RUN`.
- R2: When the synchronized scan-trigger shows no edge for more than `wdt_timeout` cycles while `wdt_enable` is high, `ch_enable` becomes all zeros.
- R3: Every edge, rising or falling, of the synchronized scan-trigger reloads the watchdog counter to `wdt_timeout`. A trigger that toggles more often than the timeout keeps the outputs on.
- R4: While `wdt_enable` is low, the scan-trigger is ignored and the watchdog never expires.
- R5: A watchdog shutdown clears on its own once scan-trigger edges resume, and `ch_enable` returns to all ones.
- R6: With `therm_en` high, a high `therm_event` forces `ch_enable` to zero within 4 cycles.
- R7: With `therm_en` low, `therm_event` has no effect on `ch_enable` or on the shutdown flag.
- R8: A thermal shutdown clears when `therm_event` goes low.
- R9: Whenever the outputs are off because of the watchdog or a thermal event, `shdn_flag_oe`=1 and `shdn_flag_d`=0. Otherwise the flag is released.
- R10: When any bit of `open_det` is 1, `disc_flag_oe`=1 and `disc_flag_d`=0.
- R11: With `flag_test_n` low, the disconnection flag is asserted regardless of `open_det`.
- R12: While `blank_n` is low, `ch_enable` is all zeros and the shutdown flag stays released.
- R13: Thermal has priority over the watchdog. When a thermal event clears while the watchdog is still expired, the outputs stay off in `ST_WDT_TRIP` until scan activity resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_enable | input | 1 | Watchdog enable (low disables it) |
| wdt_timeout | input | WDT_W | Watchdog period in cycles |
| scan_trig | input | 1 | Asynchronous scan-trigger input |
| therm_en | input | 1 | Thermal-shutdown enable |
| therm_event | input | 1 | Asynchronous thermal event |
| open_det | input | NUM_CH | Per-channel open-LED detect |
| blank_n | input | 1 | Active-low blank of all outputs |
| flag_test_n | input | 1 | Active-low disconnection flag test |
| ch_enable | output | NUM_CH | Channel drive enables |
| shdn_flag_d | output | 1 | Shutdown flag data (0 when asserted) |
| shdn_flag_oe | output | 1 | Shutdown flag output enable |
| disc_flag_d | output | 1 | Disconnection flag data (0 when asserted) |
| disc_flag_oe | output | 1 | Disconnection flag output enable |

## Verification
The hardest situation to reach is a shutdown where both causes overlap. In that case the thermal event clears while the watchdog stays expired, and the machine must fall back to `ST_WDT_TRIP` instead of `ST_RUN`. The bench first stops the scan-trigger so the watchdog trips, then raises an enabled thermal event, then drops it while the trigger is still quiet. The outputs must stay off until toggling resumes. A second hard case is the edge of the timeout window. The trigger toggles every 4 cycles against a 20-cycle timeout, and the bench checks both before and after the trigger stops, with margins that cover the synchronizer and the edge-detect latency.

// File: rtl/led_mon_pkg.sv
package led_mon_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WDT_TRIP = 2'd1,
        ST_HOT_TRIP = 2'd2
    } mon_state_e;
endpackage

// File: rtl/led_mon_sync.sv
module led_mon_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/led_mon_wdt.sv
module led_mon_wdt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] timeout,
    input  logic             trig_s,
    output logic             trig_edge,
    output logic             expired,
    output logic [CNT_W-1:0] count
);
    logic trig_prev;
    logic pending;

    assign trig_edge = trig_s ^ trig_prev;
    assign expired   = enable && !pending && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_prev <= 1'b0;
            pending   <= 1'b1;
            count     <= '0;
        end else begin
            trig_prev <= trig_s;
            if (pending || trig_edge || !enable) begin
                count   <= timeout;
                pending <= 1'b0;
            end else if (count != '0) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/led_fault_monitor.sv
module led_fault_monitor
    import led_mon_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int WDT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_enable,
    input  logic [WDT_W-1:0]  wdt_timeout,
    input  logic              scan_trig,
    input  logic              therm_en,
    input  logic              therm_event,
    input  logic [NUM_CH-1:0] open_det,
    input  logic              blank_n,
    input  logic              flag_test_n,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              shdn_flag_d,
    output logic              shdn_flag_oe,
    output logic              disc_flag_d,
    output logic              disc_flag_oe
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_in;
    logic              trig_s;
    logic              therm_act;
    logic              trig_edge;
    logic              wdt_expired;
    logic [WDT_W-1:0]  wdt_count;
    logic              tripped;
    logic              disc_any;
    mon_state_e        state_q;
    mon_state_e        state_d;

    assign raw_in = {therm_en, therm_event, scan_trig};

    led_mon_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign trig_s    = sync_in[0];
    assign therm_act = sync_in[1] & sync_in[2];

    led_mon_wdt #(.CNT_W(WDT_W)) u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (wdt_enable),
        .timeout   (wdt_timeout),
        .trig_s    (trig_s),
        .trig_edge (trig_edge),
        .expired   (wdt_expired),
        .count     (wdt_count)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (therm_act)        state_d = ST_HOT_TRIP;
                else if (wdt_expired) state_d = ST_WDT_TRIP;
            end
            ST_WDT_TRIP: begin
                if (therm_act)         state_d = ST_HOT_TRIP;
                else if (!wdt_expired) state_d = ST_RUN;
            end
            ST_HOT_TRIP: begin
                if (!therm_act) state_d = wdt_expired ? ST_WDT_TRIP : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        tripped      = (state_q != ST_RUN);
        ch_enable    = (!tripped && blank_n) ? {NUM_CH{1'b1}} : {NUM_CH{1'b0}};
        shdn_flag_oe = tripped;
        shdn_flag_d  = !tripped;
        disc_any     = (|open_det) || !flag_test_n;
        disc_flag_oe = disc_any;
        disc_flag_d  = !disc_any;
    end
endmodule

// File: rtl/led_fault_monitor_chk.sv
module led_fault_monitor_chk
    import led_mon_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int WDT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_enable,
    input logic [WDT_W-1:0]  wdt_timeout,
    input logic [NUM_CH-1:0] open_det,
    input logic              blank_n,
    input logic              flag_test_n,
    input logic [NUM_CH-1:0] ch_enable,
    input logic              shdn_flag_d,
    input logic              shdn_flag_oe,
    input logic              disc_flag_d,
    input logic              disc_flag_oe,
    input logic              therm_act,
    input logic              trig_edge,
    input logic              wdt_expired,
    input logic [WDT_W-1:0]  wdt_count,
    input mon_state_e        state_q
);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_enable && trig_edge) |=> (wdt_count == $past(wdt_timeout)));

    p_wdt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_enable |-> !wdt_expired);

    p_therm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOT_TRIP && !therm_act) |=> (state_q != ST_HOT_TRIP));

    p_shdn_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_flag_oe |-> (ch_enable == '0 && !shdn_flag_d));

    p_open_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|open_det) |-> (disc_flag_oe && !disc_flag_d));

    p_test_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_test_n |-> disc_flag_oe);

    p_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (ch_enable == '0));

    p_hot_to_wdt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOT_TRIP && !therm_act && wdt_expired) |=> (state_q == ST_WDT_TRIP));
endmodule

bind led_fault_monitor led_fault_monitor_chk #(.NUM_CH(NUM_CH), .WDT_W(WDT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_enable   (wdt_enable),
    .wdt_timeout  (wdt_timeout),
    .open_det     (open_det),
    .blank_n      (blank_n),
    .flag_test_n  (flag_test_n),
    .ch_enable    (ch_enable),
    .shdn_flag_d  (shdn_flag_d),
    .shdn_flag_oe (shdn_flag_oe),
    .disc_flag_d  (disc_flag_d),
    .disc_flag_oe (disc_flag_oe),
    .therm_act    (therm_act),
    .trig_edge    (trig_edge),
    .wdt_expired  (wdt_expired),
    .wdt_count    (wdt_count),
    .state_q      (state_q)
);

// File: tb/tb_led_fault_monitor.sv
module tb_led_fault_monitor;
    localparam int NUM_CH = 16;
    localparam int WDT_W  = 16;
    localparam logic [NUM_CH-1:0] ALL_ON = {NUM_CH{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wdt_enable = 1'b1;
    logic [WDT_W-1:0]  wdt_timeout = 16'd20;
    logic              scan_trig = 1'b0;
    logic              therm_en = 1'b1;
    logic              therm_event = 1'b0;
    logic [NUM_CH-1:0] open_det = '0;
    logic              blank_n = 1'b1;
    logic              flag_test_n = 1'b1;
    logic [NUM_CH-1:0] ch_enable;
    logic              shdn_flag_d, shdn_flag_oe, disc_flag_d, disc_flag_oe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  scan_run = 1'b0;

    always #2 clk = ~clk;

    led_fault_monitor #(.NUM_CH(NUM_CH), .WDT_W(WDT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wdt_enable(wdt_enable), .wdt_timeout(wdt_timeout),
        .scan_trig(scan_trig), .therm_en(therm_en), .therm_event(therm_event),
        .open_det(open_det), .blank_n(blank_n), .flag_test_n(flag_test_n),
        .ch_enable(ch_enable), .shdn_flag_d(shdn_flag_d), .shdn_flag_oe(shdn_flag_oe),
        .disc_flag_d(disc_flag_d), .disc_flag_oe(disc_flag_oe)
    );

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (scan_run) begin
                ph++;
                if (ph >= 4) begin
                    scan_trig = ~scan_trig;
                    ph = 0;
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_on(input string tag);
        chk(ch_enable == ALL_ON, tag, 32'(ch_enable), 32'(ALL_ON));
    endtask

    task automatic chk_off(input string tag);
        chk(ch_enable == '0, tag, 32'(ch_enable), 32'h0);
    endtask

    task automatic chk_shdn(input bit asserted, input string tag);
        chk(shdn_flag_oe == asserted && shdn_flag_d == !asserted, tag,
            {30'd0, shdn_flag_oe, shdn_flag_d}, {30'd0, asserted, !asserted});
    endtask

    task automatic t_reset;
        scan_run = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chk_on("R1 outputs on after reset");
        chk_shdn(1'b0, "R1 shutdown flag released");
        chk(disc_flag_oe == 1'b0 && disc_flag_d == 1'b1, "R1 disc flag released",
            {30'd0, disc_flag_oe, disc_flag_d}, 32'h1);
    endtask

    task automatic t_keepalive;
        wait_cyc(80);
        chk_on("R3 toggling trigger keeps outputs on");
        scan_run = 1'b0;
        wait_cyc(10);
        chk_on("R3 still on inside timeout window");
    endtask

    task automatic t_wdt_trip;
        wait_cyc(30);
        chk_off("R2 watchdog expiry turns outputs off");
        chk_shdn(1'b1, "R9 shutdown flag on watchdog");
    endtask

    task automatic t_wdt_recover;
        scan_run = 1'b1;
        wait_cyc(12);
        chk_on("R5 outputs back after scan resumes");
        chk_shdn(1'b0, "R5 shutdown flag released");
    endtask

    task automatic t_wdt_disable;
        wdt_enable = 1'b0;
        scan_run = 1'b0;
        wait_cyc(60);
        chk_on("R4 disabled watchdog ignores quiet trigger");
        chk_shdn(1'b0, "R4 no shutdown flag");
        scan_run = 1'b1;
        wait_cyc(6);
        wdt_enable = 1'b1;
        wait_cyc(30);
        chk_on("R4 re-enabled with activity stays on");
    endtask

    task automatic t_therm;
        therm_en = 1'b1;
        therm_event = 1'b1;
        wait_cyc(4);
        chk_off("R6 thermal event turns outputs off");
        chk_shdn(1'b1, "R9 shutdown flag on thermal");
        therm_event = 1'b0;
        wait_cyc(5);
        chk_on("R8 thermal shutdown clears");
        chk_shdn(1'b0, "R8 flag released");
    endtask

    task automatic t_therm_disabled;
        therm_en = 1'b0;
        therm_event = 1'b1;
        wait_cyc(10);
        chk_on("R7 thermal ignored while disabled");
        chk_shdn(1'b0, "R7 no shutdown flag");
        therm_event = 1'b0;
        therm_en = 1'b1;
        wait_cyc(5);
    endtask

    task automatic t_both;
        scan_run = 1'b0;
        wait_cyc(35);
        chk_off("R13 watchdog tripped first");
        therm_event = 1'b1;
        wait_cyc(5);
        chk_off("R13 thermal on top of watchdog");
        therm_event = 1'b0;
        wait_cyc(6);
        chk_off("R13 still off after thermal clears");
        chk_shdn(1'b1, "R13 shutdown flag held");
        scan_run = 1'b1;
        wait_cyc(12);
        chk_on("R13 on after scan resumes");
    endtask

    task automatic t_blank;
        blank_n = 1'b0;
        wait_cyc(1);
        chk_off("R12 blank turns outputs off");
        chk_shdn(1'b0, "R12 blank is not a shutdown");
        blank_n = 1'b1;
        wait_cyc(1);
        chk_on("R12 outputs return after blank");
    endtask

    task automatic t_disc;
        open_det = 16'h0100;
        wait_cyc(1);
        chk(disc_flag_oe && !disc_flag_d, "R10 open LED flags", {30'd0, disc_flag_oe, disc_flag_d}, 32'h2);
        open_det = '0;
        wait_cyc(1);
        chk(!disc_flag_oe && disc_flag_d, "R10 flag clears", {30'd0, disc_flag_oe, disc_flag_d}, 32'h1);
        flag_test_n = 1'b0;
        wait_cyc(1);
        chk(disc_flag_oe && !disc_flag_d, "R11 test forces flag", {30'd0, disc_flag_oe, disc_flag_d}, 32'h2);
        flag_test_n = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        t_reset();
        t_keepalive();
        t_wdt_trip();
        t_wdt_recover();
        t_wdt_disable();
        t_therm();
        t_therm_disabled();
        t_both();
        t_blank();
        t_disc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule